// File: doc/BRIEF.md
# SDRAM Command Sequence Monitor

This block is a passive observer for the command bus of a two-bank synchronous DRAM. It samples the chip-select, row-strobe, column-strobe and write-enable pins every clock, together with the bank select, address bit 10 and the three low address bits that carry the burst-length field. From these it decodes one command per cycle and keeps its own model of the device: whether each bank has an open row, how long ago each bank was closed, how long ago the mode register was written, and which bank is due to close itself when an auto-precharged burst ends.

When a sampled command breaks a sequencing rule, the monitor raises a one-cycle error pulse with a three-bit code naming the rule. A sticky flag records that some violation has occurred and holds until reset. A command that breaks a rule is treated as if the device ignored it, so the model stays consistent for the commands that follow. The monitor drives nothing onto the bus. It is meant to sit beside a memory controller in simulation or in silicon debug logic.

Top module: `sdr_cmd_checker`

## Requirements
- R1: A cycle with cs_n high (inhibit), a NOP (cs_n low and ras_n, cas_n and we_n high), an auto-refresh (pins 0001) or a burst-stop (pins 0110) changes no bank state and raises no error. Pins are listed as {cs_n, ras_n, cas_n, we_n}.
- R2: A READ (0101) or WRITE (0100) to a bank with no open row gives error code 1.
- R3: An ACTIVE (0011) to a bank whose row is already open gives error code 2. An accepted ACTIVE opens the bank.
- R4: An ACTIVE to a closed bank in a cycle fewer than T_RP cycles after the cycle that closed it gives error code 3. At T_RP cycles or later it is accepted.
- R5: A LOAD MODE (0000) while any bank is open gives error code 4. An accepted LOAD MODE captures addr_lo as the burst code: 000, 001, 010 and 011 select lengths 1, 2, 4 and 8, 111 selects full page, and other codes count as length 1.
- R6: Any command other than inhibit or NOP issued fewer than T_MRD cycles after an accepted LOAD MODE gives error code 5. This rule takes priority over every other code.
- R7: A PRECHARGE (0010) with a10 high closes every open bank regardless of ba. With a10 low it closes only bank ba. Each bank it closes starts its T_RP interval in that cycle.
- R8: A READ or WRITE with a10 high, accepted in cycle t with burst length BL, closes its bank in cycle t+BL, acting exactly like a PRECHARGE issued in that cycle. The bank still counts as open during cycle t+BL.
- R9: In full-page mode (burst code 111), a10 on READ or WRITE has no effect and the bank stays open.
- R10: A command that raises an error changes no model state. A rejected LOAD MODE starts no T_MRD window and does not change the burst code.
- R11: err_valid rises at the clock edge that samples the offending command and stays high for that one cycle only. err_code is 0 whenever err_valid is low. err_sticky sets together with the first pulse and holds until reset.
- R12: After reset, all banks are closed with no interval running, the burst code is 000, and err_valid, err_code and err_sticky are all 0.
- R13: A READ or WRITE accepted on a bank replaces any burst bookkeeping already held for that bank, including in the cycle its earlier auto-close was due.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (1) | Bank select |
| a10 | input | 1 | Precharge-all / auto-precharge select |
| addr_lo | input | 3 | Address bits 2..0; burst code on LOAD MODE |
| err_valid | output | 1 | One-cycle violation pulse |
| err_code | output | 3 | Violation code, 1..5, 0 when no pulse |
| err_sticky | output | 1 | Set by any violation, cleared by reset |

## Verification
The assertions assume that the pins carry known values on every edge once reset is released, that ba only selects banks that exist, and that reset is held for at least one edge before the first command. They also treat every pin pattern other than inhibit and NOP as a real command for the mode-write window. The bench drives all pins on the falling edge from tasks, starts each scenario from reset, and always parks the bus on inhibit. So no pin is ever undriven, and no command lands in a window the scenario did not plan for.

// File: rtl/sdr_chk_pkg.sv
package sdr_chk_pkg;

    // Burst-end counter width: covers the longest finite burst (8)
    localparam int BURST_W = 4;

    typedef enum logic [2:0] {
        CMD_INH   = 3'd0,
        CMD_NOP   = 3'd1,
        CMD_ACT   = 3'd2,
        CMD_RD    = 3'd3,
        CMD_WR    = 3'd4,
        CMD_PRE   = 3'd5,
        CMD_LMR   = 3'd6,
        CMD_OTHER = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        V_NONE     = 3'd0,
        V_ACC_IDLE = 3'd1,
        V_ACT_OPEN = 3'd2,
        V_ACT_TRP  = 3'd3,
        V_LMR_BUSY = 3'd4,
        V_MRD      = 3'd5
    } viol_e;

    typedef struct packed {
        cmd_e       op;
        logic       exec;
        logic       a10;
        logic [2:0] blc;
    } cmd_t;

    function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
        cmd_e r;
        if (cs_n) begin
            r = CMD_INH;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  r = CMD_NOP;
                3'b011:  r = CMD_ACT;
                3'b101:  r = CMD_RD;
                3'b100:  r = CMD_WR;
                3'b010:  r = CMD_PRE;
                3'b000:  r = CMD_LMR;
                default: r = CMD_OTHER;
            endcase
        end
        return r;
    endfunction

    function automatic logic [BURST_W-1:0] burst_len_of(input logic [2:0] code);
        logic [BURST_W-1:0] one;
        one = BURST_W'(1);
        return code[2] ? one : (one << code[1:0]);
    endfunction

    function automatic logic is_full_page(input logic [2:0] code);
        return code == 3'b111;
    endfunction

endpackage

// File: rtl/sdr_chk_decode.sv
module sdr_chk_decode
    import sdr_chk_pkg::*;
(
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       a10,
    input  logic [2:0] addr_lo,
    output cmd_t       dec
);

    cmd_e op;

    always_comb begin
        op       = decode_pins(cs_n, ras_n, cas_n, we_n);
        dec.op   = op;
        dec.exec = (op != CMD_INH) && (op != CMD_NOP);
        dec.a10  = a10;
        dec.blc  = addr_lo;
    end

endmodule

// File: rtl/sdr_chk_mode.sv
module sdr_chk_mode
    import sdr_chk_pkg::*;
#(
    parameter int T_MRD = 2,
    localparam int MRD_W = (T_MRD > 1) ? $clog2(T_MRD + 1) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [2:0]         code_in,
    output logic [BURST_W-1:0] burst_len,
    output logic               full_page,
    output logic               mrd_busy
);

    logic [2:0]       code_q;
    logic [MRD_W-1:0] mrd_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= 3'b000;
            mrd_cnt <= '0;
        end else if (load) begin
            code_q  <= code_in;
            mrd_cnt <= MRD_W'(T_MRD - 1);
        end else if (mrd_cnt != '0) begin
            mrd_cnt <= mrd_cnt - 1'b1;
        end
    end

    assign burst_len = burst_len_of(code_q);
    assign full_page = is_full_page(code_q);
    assign mrd_busy  = (mrd_cnt != '0);

endmodule

// File: rtl/sdr_chk_bank.sv
module sdr_chk_bank
    import sdr_chk_pkg::*;
#(
    parameter int T_RP = 3,
    localparam int RP_W = (T_RP > 1) ? $clog2(T_RP + 1) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               do_act,
    input  logic               do_pre,
    input  logic               do_rdwr,
    input  logic               rdwr_ap,
    input  logic [BURST_W-1:0] burst_len,
    output logic               is_open,
    output logic               trp_busy
);

    logic               open_q;
    logic [RP_W-1:0]    rp_cnt;
    logic               ap_pend;
    logic [BURST_W-1:0] bcnt;
    logic               ap_fire;

    // auto-close is due in the cycle the burst counter shows its last beat
    assign ap_fire = ap_pend && (bcnt == BURST_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            rp_cnt  <= '0;
            ap_pend <= 1'b0;
            bcnt    <= '0;
        end else begin
            if (rp_cnt != '0) rp_cnt <= rp_cnt - 1'b1;
            if (bcnt != '0)   bcnt   <= bcnt - 1'b1;

            if (do_act) begin
                open_q <= 1'b1;
            end else if (do_pre) begin
                if (open_q) begin
                    open_q <= 1'b0;
                    rp_cnt <= RP_W'(T_RP - 1);
                end
                ap_pend <= 1'b0;
            end else if (do_rdwr) begin
                ap_pend <= rdwr_ap;
                bcnt    <= burst_len;
            end else if (ap_fire) begin
                open_q  <= 1'b0;
                rp_cnt  <= RP_W'(T_RP - 1);
                ap_pend <= 1'b0;
            end
        end
    end

    assign is_open  = open_q;
    assign trp_busy = (rp_cnt != '0);

endmodule

// File: rtl/sdr_cmd_checker.sv
module sdr_cmd_checker
    import sdr_chk_pkg::*;
#(
    parameter int N_BANKS = 2,
    parameter int T_RP    = 3,
    parameter int T_MRD   = 2,
    localparam int BA_W   = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    input  logic [2:0]      addr_lo,
    output logic            err_valid,
    output logic [2:0]      err_code,
    output logic            err_sticky
);

    cmd_t               dec;
    viol_e              viol;
    logic               accept;
    logic [N_BANKS-1:0] bank_open;
    logic [N_BANKS-1:0] trp_busy;
    logic [BURST_W-1:0] burst_len;
    logic               full_page;
    logic               mrd_busy;
    logic               lmr_load;

    sdr_chk_decode u_decode (
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .a10     (a10),
        .addr_lo (addr_lo),
        .dec     (dec)
    );

    // rule evaluation; the mode-write window outranks every other rule
    always_comb begin
        viol = V_NONE;
        if (mrd_busy && dec.exec) begin
            viol = V_MRD;
        end else begin
            case (dec.op)
                CMD_ACT: begin
                    if (bank_open[ba])     viol = V_ACT_OPEN;
                    else if (trp_busy[ba]) viol = V_ACT_TRP;
                end
                CMD_RD, CMD_WR: begin
                    if (!bank_open[ba])    viol = V_ACC_IDLE;
                end
                CMD_LMR: begin
                    if (|bank_open)        viol = V_LMR_BUSY;
                end
                default: ;
            endcase
        end
    end

    assign accept   = (viol == V_NONE);
    assign lmr_load = accept && (dec.op == CMD_LMR);

    sdr_chk_mode #(.T_MRD(T_MRD)) u_mode (
        .clk       (clk),
        .rst       (rst),
        .load      (lmr_load),
        .code_in   (dec.blc),
        .burst_len (burst_len),
        .full_page (full_page),
        .mrd_busy  (mrd_busy)
    );

    generate
        for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
            logic sel;
            logic act_g;
            logic pre_g;
            logic rdwr_g;

            assign sel    = (ba == BA_W'(g));
            assign act_g  = accept && (dec.op == CMD_ACT) && sel;
            assign pre_g  = accept && (dec.op == CMD_PRE) && (dec.a10 || sel);
            assign rdwr_g = accept && ((dec.op == CMD_RD) || (dec.op == CMD_WR)) && sel;

            sdr_chk_bank #(.T_RP(T_RP)) u_bank (
                .clk       (clk),
                .rst       (rst),
                .do_act    (act_g),
                .do_pre    (pre_g),
                .do_rdwr   (rdwr_g),
                .rdwr_ap   (dec.a10 && !full_page),
                .burst_len (burst_len),
                .is_open   (bank_open[g]),
                .trp_busy  (trp_busy[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            err_valid  <= 1'b0;
            err_code   <= 3'd0;
            err_sticky <= 1'b0;
        end else begin
            err_valid  <= !accept;
            err_code   <= viol;
            if (!accept) err_sticky <= 1'b1;
        end
    end

endmodule

// File: rtl/sdr_cmd_checker_sva.sv
module sdr_cmd_checker_sva #(
    parameter int N_BANKS = 2,
    localparam int BA_W   = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               cs_n,
    input logic               ras_n,
    input logic               cas_n,
    input logic               we_n,
    input logic [BA_W-1:0]    ba,
    input logic [N_BANKS-1:0] bank_open,
    input logic [N_BANKS-1:0] trp_busy,
    input logic               mrd_busy,
    input logic               err_valid,
    input logic [2:0]         err_code,
    input logic               err_sticky
);

    logic sel, idle_pins, is_nop, is_act, is_rdwr, is_lmr, is_exec;

    assign sel       = !cs_n;
    assign idle_pins = ras_n && cas_n && we_n;
    assign is_nop    = sel && idle_pins;
    assign is_exec   = sel && !idle_pins;
    assign is_act    = sel && !ras_n && cas_n && we_n;
    assign is_rdwr   = sel && ras_n && !cas_n;
    assign is_lmr    = sel && !ras_n && !cas_n && !we_n;

    AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !err_valid);                                               // R1
    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        is_nop |=> !err_valid);                                             // R1
    AST_ACCESS_IDLE: assert property (@(posedge clk) disable iff (rst)
        is_rdwr && !mrd_busy && !bank_open[ba] |=> err_valid && err_code == 3'd1); // R2
    AST_ACT_ON_OPEN: assert property (@(posedge clk) disable iff (rst)
        is_act && !mrd_busy && bank_open[ba] |=> err_code == 3'd2);         // R3
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        is_act && !mrd_busy && !bank_open[ba] && !trp_busy[ba] |=> bank_open[$past(ba)]); // R3
    AST_ACT_EARLY: assert property (@(posedge clk) disable iff (rst)
        is_act && !mrd_busy && !bank_open[ba] && trp_busy[ba] |=> err_code == 3'd3); // R4
    AST_LMR_BUSY: assert property (@(posedge clk) disable iff (rst)
        is_lmr && !mrd_busy && (|bank_open) |=> err_code == 3'd4);          // R5
    AST_MRD_WINDOW: assert property (@(posedge clk) disable iff (rst)
        is_exec && mrd_busy |=> err_valid && err_code == 3'd5);             // R6
    AST_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !err_valid |-> err_code == 3'd0);                                   // R11
    AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> err_code != 3'd0);                                    // R11
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky);                                         // R11
    AST_PULSE_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> err_sticky);                                          // R11

endmodule

bind sdr_cmd_checker sdr_cmd_checker_sva #(.N_BANKS(N_BANKS)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .ba         (ba),
    .bank_open  (bank_open),
    .trp_busy   (trp_busy),
    .mrd_busy   (mrd_busy),
    .err_valid  (err_valid),
    .err_code   (err_code),
    .err_sticky (err_sticky)
);

// File: tb/sdr_cmd_checker_bench.sv
module sdr_cmd_checker_bench;

    localparam int CLK_PERIOD = 10;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] P_INH = 4'b1111;
    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_ACT = 4'b0011;
    localparam logic [3:0] P_RD  = 4'b0101;
    localparam logic [3:0] P_WR  = 4'b0100;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_LMR = 4'b0000;
    localparam logic [3:0] P_REF = 4'b0001;
    localparam logic [3:0] P_BST = 4'b0110;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [0:0] ba = 1'b0;
    logic       a10 = 1'b0;
    logic [2:0] addr_lo = 3'b000;
    logic       err_valid, err_sticky;
    logic [2:0] err_code;

    int   n_chk = 0;
    int   n_bad = 0;
    logic got_v;
    logic [2:0] got_c;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdr_cmd_checker u_sdr_cmd_checker (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .addr_lo(addr_lo),
        .err_valid(err_valid), .err_code(err_code), .err_sticky(err_sticky)
    );

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = P_INH;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic issue(input logic [3:0] p, input logic b, input logic a, input logic [2:0] m);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = p;
        ba = b; a10 = a; addr_lo = m;
        @(posedge clk);
        #1;
        got_v = err_valid;
        got_c = err_code;
    endtask

    task automatic want(input logic [2:0] e, input string req);
        n_chk++;
        if (got_v !== (e != 3'd0) || got_c !== e) begin
            n_bad++;
            $display("FAIL %s: valid=%0b code=%0d, expected valid=%0b code=%0d",
                     req, got_v, got_c, (e != 3'd0), e);
        end
    endtask

    task automatic go(input logic [3:0] p, input logic b, input logic a,
                      input logic [2:0] m, input logic [2:0] e, input string req);
        issue(p, b, a, m);
        want(e, req);
    endtask

    task automatic want_sticky(input logic e, input string req);
        n_chk++;
        if (err_sticky !== e) begin
            n_bad++;
            $display("FAIL %s: sticky=%0b, expected %0b", req, err_sticky, e);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        got_v = err_valid; got_c = err_code;
        want(3'd0, "R12 outputs after reset");
        want_sticky(1'b0, "R12 sticky after reset");
        go(P_RD, 1'b0, 1'b0, 3'b000, 3'd1, "R12 bank0 closed after reset");
    endtask

    task automatic t_quiet_cycles();
        do_reset();
        go(4'b1011, 1'b0, 1'b0, 3'b000, 3'd0, "R1 inhibit with ACT pattern");
        go(P_RD,  1'b0, 1'b0, 3'b000, 3'd1, "R1 inhibit opened nothing");
        go(P_NOP, 1'b0, 1'b0, 3'b000, 3'd0, "R1 nop quiet");
        go(P_REF, 1'b0, 1'b0, 3'b000, 3'd0, "R1 refresh quiet");
        go(P_BST, 1'b0, 1'b0, 3'b000, 3'd0, "R1 burst stop quiet");
        go(P_WR,  1'b1, 1'b0, 3'b000, 3'd1, "R2 write to closed bank1");
    endtask

    task automatic t_act_open();
        do_reset();
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd0, "R3 first activate");
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd2, "R3 activate open bank");
        go(P_ACT, 1'b1, 1'b0, 3'b000, 3'd0, "R3 other bank independent");
        go(P_RD,  1'b1, 1'b0, 3'b000, 3'd0, "R3 read opened bank1");
    endtask

    task automatic t_trp();
        do_reset();
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd0, "R4 open");
        go(P_PRE, 1'b0, 1'b0, 3'b000, 3'd0, "R4 precharge");
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd3, "R4 one cycle after close");
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd3, "R4 two cycles after close");
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd0, "R4 at T_RP");
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd2, "R10 rejected acts left state, now open");
    endtask

    task automatic t_precharge();
        do_reset();
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd0, "R7 open b0");
        go(P_ACT, 1'b1, 1'b0, 3'b000, 3'd0, "R7 open b1");
        go(P_PRE, 1'b0, 1'b1, 3'b000, 3'd0, "R7 precharge all");
        repeat (3) go(P_NOP, 1'b0, 1'b0, 3'b000, 3'd0, "R7 idle");
        go(P_RD,  1'b1, 1'b0, 3'b000, 3'd1, "R7 all closed b1");
        go(P_RD,  1'b0, 1'b0, 3'b000, 3'd1, "R7 all closed b0");
        do_reset();
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd0, "R7 open b0");
        go(P_ACT, 1'b1, 1'b0, 3'b000, 3'd0, "R7 open b1");
        go(P_PRE, 1'b1, 1'b0, 3'b000, 3'd0, "R7 precharge b1 only");
        go(P_NOP, 1'b0, 1'b0, 3'b000, 3'd0, "R7 idle");
        go(P_RD,  1'b0, 1'b0, 3'b000, 3'd0, "R7 b0 still open");
        go(P_RD,  1'b1, 1'b0, 3'b000, 3'd1, "R7 b1 closed");
    endtask

    task automatic t_mode_load();
        do_reset();
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd0, "R5 open");
        go(P_LMR, 1'b0, 1'b0, 3'b010, 3'd4, "R5 load with open bank");
        go(P_RD,  1'b0, 1'b0, 3'b000, 3'd0, "R10 no window after rejected load");
        go(P_PRE, 1'b0, 1'b0, 3'b000, 3'd0, "R5 close");
        repeat (3) go(P_NOP, 1'b0, 1'b0, 3'b000, 3'd0, "R5 idle");
        go(P_LMR, 1'b0, 1'b0, 3'b010, 3'd0, "R5 legal load");
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd5, "R6 act inside window");
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd0, "R6 act after window");
        do_reset();
        go(P_LMR, 1'b0, 1'b0, 3'b000, 3'd0, "R6 load");
        go(P_RD,  1'b0, 1'b0, 3'b000, 3'd5, "R6 priority over closed-bank read");
        do_reset();
        go(P_LMR, 1'b0, 1'b0, 3'b000, 3'd0, "R6 load");
        go(P_NOP, 1'b0, 1'b0, 3'b000, 3'd0, "R6 nop allowed in window");
        go(P_RD,  1'b0, 1'b0, 3'b000, 3'd1, "R6 window over");
    endtask

    task automatic t_auto_close();
        do_reset();
        go(P_LMR, 1'b0, 1'b0, 3'b010, 3'd0, "R8 length 4");
        go(P_NOP, 1'b0, 1'b0, 3'b000, 3'd0, "R8 idle");
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd0, "R8 open");
        go(P_RD,  1'b0, 1'b1, 3'b000, 3'd0, "R8 read with auto close");
        repeat (3) go(P_NOP, 1'b0, 1'b0, 3'b000, 3'd0, "R8 burst");
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd2, "R8 still open at t+BL");
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd3, "R8 closed, T_RP 1");
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd3, "R8 closed, T_RP 2");
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd0, "R8 reopen");
        do_reset();
        go(P_LMR, 1'b0, 1'b0, 3'b001, 3'd0, "R8 length 2");
        go(P_NOP, 1'b0, 1'b0, 3'b000, 3'd0, "R8 idle");
        go(P_ACT, 1'b1, 1'b0, 3'b000, 3'd0, "R8 open b1");
        go(P_WR,  1'b1, 1'b1, 3'b000, 3'd0, "R8 write with auto close");
        repeat (2) go(P_NOP, 1'b0, 1'b0, 3'b000, 3'd0, "R8 burst");
        go(P_RD,  1'b1, 1'b0, 3'b000, 3'd1, "R8 b1 closed after write burst");
        do_reset();
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd0, "R8 open, length 1");
        go(P_RD,  1'b0, 1'b1, 3'b000, 3'd0, "R8 read auto close");
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd2, "R8 open in close cycle");
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd3, "R8 T_RP from close cycle");
    endtask

    task automatic t_full_page();
        do_reset();
        go(P_LMR, 1'b0, 1'b0, 3'b111, 3'd0, "R9 full page");
        go(P_NOP, 1'b0, 1'b0, 3'b000, 3'd0, "R9 idle");
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd0, "R9 open");
        go(P_WR,  1'b0, 1'b1, 3'b000, 3'd0, "R9 write with a10");
        repeat (10) go(P_NOP, 1'b0, 1'b0, 3'b000, 3'd0, "R9 wait");
        go(P_RD,  1'b0, 1'b0, 3'b000, 3'd0, "R9 bank stays open");
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd2, "R9 still open for act");
    endtask

    task automatic t_replace();
        do_reset();
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd0, "R13 open");
        go(P_RD,  1'b0, 1'b1, 3'b000, 3'd0, "R13 read auto close");
        go(P_RD,  1'b0, 1'b0, 3'b000, 3'd0, "R13 plain read in close cycle");
        go(P_ACT, 1'b0, 1'b0, 3'b000, 3'd2, "R13 auto close cancelled");
    endtask

    task automatic t_sticky();
        do_reset();
        go(P_RD,  1'b0, 1'b0, 3'b000, 3'd1, "R11 trigger");
        want_sticky(1'b1, "R11 sticky set");
        go(P_NOP, 1'b0, 1'b0, 3'b000, 3'd0, "R11 pulse one cycle");
        want_sticky(1'b1, "R11 sticky held");
        do_reset();
        #1;
        want_sticky(1'b0, "R11 sticky cleared by reset");
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_quiet_cycles();
        t_act_open();
        t_trp();
        t_precharge();
        t_mode_load();
        t_auto_close();
        t_full_page();
        t_replace();
        t_sticky();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run incomplete, expected finish before limit");
        finish_run();
    end

endmodule